// File: doc/BRIEF.md
# Row-Bus Hybrid Address Network

This block carries cache addresses from a cache controller to a grid of cache banks arranged in rows and columns. The controller holds one point-to-point link per row. Each link ends at a row router. The router queues incoming addresses and launches each one onto its row's bus. The bus is pipelined, has a single master and delivers the address to every bank in the row in the same cycle. No bus needs arbitration because only its own router drives it. Addresses for different rows travel on separate links and buses, so they are in flight at the same time without interfering.

A request is a valid strobe, a destination row index and an address. The block takes it on any clock edge where the target row reports ready. Each row has a credit counter. It covers the addresses still on that row's link and in its router queue. When the queue could overflow, the row withdraws ready, and requests offered to that row are then ignored. The router launches at most one address every `BUS_GAP` cycles, which matches the cycle time of the banks. Addresses to one row leave in the order they were accepted. The link, router and bus latencies are all parameters.

Top module: `rowbus_addr_net`

## Requirements
- R1: In the first cycle after reset, every bank valid output is low and `in_ready` is high.
- R2: With its row idle, an accepted address appears at that row's banks exactly LINK_LAT+RTR_LAT+BUS_LAT cycles after the accepting edge, counting the accepting edge as cycle 1. The default total is 1+3+2 = 6. No address arrives sooner than this.
- R3: A delivery raises the valid output of all COLS banks in the target row in the same cycle, with the same address. Bank `r*COLS+c` sits at bit index `r*COLS+c` of `bank_valid` and at slice `[(r*COLS+c)*ADDR_W +: ADDR_W]` of `bank_addr`. Banks of other rows do not see it.
- R4: Addresses accepted for different rows on consecutive cycles each reach their row with the idle latency of R2. The rows do not delay one another.
- R5: Addresses for the same row reach the banks in the order in which they were accepted.
- R6: Two deliveries on one row are at least BUS_GAP cycles apart. The default BUS_GAP is 2.
- R7: A row may hold at most FIFO_DEPTH accepted addresses that its router has not yet launched. While it holds that many, `in_ready` is low for requests to that row, and such a request is dropped: it is never delivered.
- R8: A row that has withdrawn ready does not block requests to another row.
- R9: Every accepted address is delivered exactly once. No delivery happens without a matching accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe from the controller |
| in_row | input | ROW_W | Destination row index |
| in_addr | input | ADDR_W | Address to deliver |
| in_ready | output | 1 | The destination row can accept this request |
| bank_valid | output | ROWS*COLS | Per-bank address strobe, index r*COLS+c |
| bank_addr | output | ROWS*COLS*ADDR_W | Per-bank address, slice r*COLS+c |

## Verification
A wrong credit count shows in one of two ways. Ready may stay high past the queue limit, so addresses are lost or repeated, and the scoreboard sees a missing or extra delivery within a few cycles. Or ready may drop early, so a request to a nearly empty row is refused on the spot. A wrong pacing counter shows as two deliveries on one row fewer than BUS_GAP cycles apart, at the next launch. An extra or missing pipeline stage shifts the idle latency, and the first directed request of each idle test catches that. A queue pointer error swaps or repeats addresses on a row, and the in-order comparison against the bench's per-row queues flags it at that delivery.

// File: rtl/rbn_pkg.sv
package rbn_pkg;
  // index width that never collapses to zero bits
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
  // width of a counter that must hold the value n itself
  function automatic int cnt_w(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/rbn_pipe.sv
module rbn_pipe #(
  parameter int W      = 24,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);
  generate
    if (STAGES == 0) begin : g_wire
      assign out_v = in_v;
      assign out_d = in_d;
    end else begin : g_regs
      logic         v_q [STAGES];
      logic [W-1:0] d_q [STAGES];
      always_ff @(posedge clk) begin
        if (rst) v_q[0] <= 1'b0;
        else     v_q[0] <= in_v;
        d_q[0] <= in_d;
      end
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
          if (rst) v_q[s] <= 1'b0;
          else     v_q[s] <= v_q[s-1];
          d_q[s] <= d_q[s-1];
        end
      end
      assign out_v = v_q[STAGES-1];
      assign out_d = d_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/rbn_fifo.sv
module rbn_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty
);
  import rbn_pkg::*;
  localparam int PW = idx_w(DEPTH);
  localparam int CW = cnt_w(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] count;

  // plain write port, registered read port: maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
    if (rd_en) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_en) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (rd_en) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign empty = (count == '0);
endmodule

// File: rtl/rbn_row_router.sv
module rbn_row_router #(
  parameter int W       = 24,
  parameter int DEPTH   = 4,
  parameter int RTR_LAT = 3,
  parameter int BUS_GAP = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         launch,
  output logic         out_v,
  output logic [W-1:0] out_d
);
  import rbn_pkg::*;
  localparam int GW   = cnt_w(BUS_GAP);
  localparam int TAIL = (RTR_LAT > 2) ? RTR_LAT - 2 : 0;

  logic          empty;
  logic [W-1:0]  rd_data;
  logic          rd_v_q;
  logic [GW-1:0] gap_q;

  assign launch = !empty && (gap_q == '0);

  rbn_fifo #(.W(W), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst(rst),
    .wr_en(in_v), .wr_data(in_d),
    .rd_en(launch), .rd_data(rd_data),
    .empty(empty)
  );

  // pacing: one launch per BUS_GAP cycles
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      rd_v_q <= 1'b0;
    end else begin
      rd_v_q <= launch;
      if (launch)            gap_q <= GW'(BUS_GAP - 1);
      else if (gap_q != '0)  gap_q <= gap_q - 1'b1;
    end
  end

  rbn_pipe #(.W(W), .STAGES(TAIL)) tail_i (
    .clk(clk), .rst(rst),
    .in_v(rd_v_q), .in_d(rd_data),
    .out_v(out_v), .out_d(out_d)
  );
endmodule

// File: rtl/rowbus_addr_net.sv
module rowbus_addr_net #(
  parameter int ADDR_W     = 24,
  parameter int ROWS       = 4,
  parameter int COLS       = 4,
  parameter int LINK_LAT   = 1,
  parameter int RTR_LAT    = 3,
  parameter int BUS_LAT    = 2,
  parameter int BUS_GAP    = 2,
  parameter int FIFO_DEPTH = 4,
  localparam int ROW_W     = rbn_pkg::idx_w(ROWS),
  localparam int BANKS     = ROWS * COLS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [ROW_W-1:0]        in_row,
  input  logic [ADDR_W-1:0]       in_addr,
  output logic                    in_ready,
  output logic [BANKS-1:0]        bank_valid,
  output logic [BANKS*ADDR_W-1:0] bank_addr
);
  import rbn_pkg::*;
  localparam int CW = cnt_w(FIFO_DEPTH);

  logic [ROWS-1:0] row_rdy;
  logic [ROWS-1:0] row_take;
  logic [ROWS-1:0] row_launch;

  always_comb begin
    in_ready = 1'b0;
    for (int r = 0; r < ROWS; r++)
      if (in_row == ROW_W'(r)) in_ready = row_rdy[r];
  end

  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic [CW-1:0]     credit_q;
      logic              lnk_v, rtr_v, bus_v;
      logic [ADDR_W-1:0] lnk_d, rtr_d, bus_d;

      assign row_rdy[r]  = (credit_q < CW'(FIFO_DEPTH));
      assign row_take[r] = in_valid && (in_row == ROW_W'(r)) && row_rdy[r];

      // credits cover the link stages plus the router queue
      always_ff @(posedge clk) begin
        if (rst) credit_q <= '0;
        else case ({row_take[r], row_launch[r]})
          2'b10:   credit_q <= credit_q + 1'b1;
          2'b01:   credit_q <= credit_q - 1'b1;
          default: credit_q <= credit_q;
        endcase
      end

      rbn_pipe #(.W(ADDR_W), .STAGES(LINK_LAT)) link_i (
        .clk(clk), .rst(rst),
        .in_v(row_take[r]), .in_d(in_addr),
        .out_v(lnk_v), .out_d(lnk_d)
      );

      rbn_row_router #(.W(ADDR_W), .DEPTH(FIFO_DEPTH),
                       .RTR_LAT(RTR_LAT), .BUS_GAP(BUS_GAP)) rtr_i (
        .clk(clk), .rst(rst),
        .in_v(lnk_v), .in_d(lnk_d),
        .launch(row_launch[r]),
        .out_v(rtr_v), .out_d(rtr_d)
      );

      rbn_pipe #(.W(ADDR_W), .STAGES(BUS_LAT)) bus_i (
        .clk(clk), .rst(rst),
        .in_v(rtr_v), .in_d(rtr_d),
        .out_v(bus_v), .out_d(bus_d)
      );

      // every bank on the row taps the final bus stage
      for (genvar c = 0; c < COLS; c++) begin : g_tap
        assign bank_valid[r*COLS + c]                = bus_v;
        assign bank_addr[(r*COLS + c)*ADDR_W +: ADDR_W] = bus_d;
      end
    end
  endgenerate
endmodule

// File: rtl/rbn_checker.sv
module rbn_checker #(
  parameter int ROWS       = 4,
  parameter int COLS       = 4,
  parameter int ROW_W      = 2,
  parameter int BUS_GAP    = 2,
  parameter int FIFO_DEPTH = 4,
  parameter int RTR_LAT    = 3,
  parameter int BUS_LAT    = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [ROW_W-1:0]     in_row,
  input logic                 in_ready,
  input logic [ROWS*COLS-1:0] bank_valid
);
  localparam int LIMIT = FIFO_DEPTH + RTR_LAT + BUS_LAT;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (bank_valid == '0) && in_ready);

  for (genvar r = 0; r < ROWS; r++) begin : g_chk
    int  outst;
    int  since;
    logic acc, dlv;
    assign acc = in_valid && in_ready && (in_row == ROW_W'(r));
    assign dlv = bank_valid[r*COLS];

    always_ff @(posedge clk) begin
      if (rst) begin
        outst <= 0;
        since <= BUS_GAP;
      end else begin
        outst <= outst + (acc ? 1 : 0) - (dlv ? 1 : 0);
        if (dlv)                since <= 1;
        else if (since < BUS_GAP) since <= since + 1;
      end
    end

    assert_bus_gap_R6: assert property (@(posedge clk) disable iff (rst)
      dlv |-> (since >= BUS_GAP));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
      outst <= LIMIT);

    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (rst)
      dlv |-> (outst > 0));
  end
endmodule

bind rowbus_addr_net rbn_checker #(
  .ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .BUS_GAP(BUS_GAP),
  .FIFO_DEPTH(FIFO_DEPTH), .RTR_LAT(RTR_LAT), .BUS_LAT(BUS_LAT)
) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_row(in_row),
  .in_ready(in_ready), .bank_valid(bank_valid)
);

// File: tb/rowbus_addr_net_tb_top.sv
module rowbus_addr_net_tb_top;
  localparam int AW = 24, ROWS = 4, COLS = 4, RW = 2;
  localparam int LAT = 1 + 3 + 2;
  localparam int GAP = 2, DEPTH = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0;
  logic [RW-1:0] in_row = '0;
  logic [AW-1:0] in_addr = '0;
  logic in_ready;
  logic [ROWS*COLS-1:0] bank_valid;
  logic [ROWS*COLS*AW-1:0] bank_addr;

  int tests = 0, fails = 0, cyc = 0;
  bit chk_exact = 0;
  logic [AW-1:0] q  [ROWS][$];
  int            tq [ROWS][$];
  int            last_d [ROWS];

  always #5 clk = ~clk;

  rowbus_addr_net dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_row(in_row),
    .in_addr(in_addr), .in_ready(in_ready),
    .bank_valid(bank_valid), .bank_addr(bank_addr)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // scoreboard on the bank outputs
  always @(negedge clk) begin
    if (!rst) begin
      for (int r = 0; r < ROWS; r++) begin
        logic v0;
        logic [AW-1:0] a0;
        v0 = bank_valid[r*COLS];
        a0 = bank_addr[r*COLS*AW +: AW];
        for (int c = 1; c < COLS; c++)
          if (bank_valid[r*COLS+c] !== v0 ||
              (v0 && bank_addr[(r*COLS+c)*AW +: AW] !== a0))
            check(0, "R3", int'(bank_addr[(r*COLS+c)*AW +: AW]), int'(a0));
        if (v0) begin
          if (q[r].size() == 0) begin
            check(0, "R9", 1, 0);
          end else begin
            logic [AW-1:0] ea;
            int lat;
            ea  = q[r].pop_front();
            lat = cyc - tq[r].pop_front() + 1;
            check(a0 === ea, "R5", int'(a0), int'(ea));
            if (chk_exact) check(lat == LAT, "R2", lat, LAT);
            else           check(lat >= LAT, "R2", lat, LAT);
            if (last_d[r] >= 0)
              check(cyc - last_d[r] >= GAP, "R6", cyc - last_d[r], GAP);
          end
          last_d[r] = cyc;
        end
      end
    end
  end

  task automatic send(input int r, input logic [AW-1:0] a, output bit acc);
    @(negedge clk);
    in_valid = 1'b1;
    in_row   = RW'(r);
    in_addr  = a;
    #1;
    acc = in_ready;
    if (acc) begin
      q[r].push_back(a);
      tq[r].push_back(cyc + 1);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", cyc, 200000);
    finish_run();
  end

  initial begin
    bit acc;
    int refused;
    void'($urandom(32'd1234));
    for (int r = 0; r < ROWS; r++) last_d[r] = -100;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check(bank_valid == '0, "R1", int'(bank_valid), 0);
    check(in_ready === 1'b1, "R1", int'(in_ready), 1);

    // single request per row on an idle network: exact latency, broadcast
    chk_exact = 1;
    for (int r = 0; r < ROWS; r++) begin
      send(r, AW'(24'h100000 + r), acc);
      check(acc, "R1", int'(acc), 1);
      idle(LAT + 2);
    end
    // different rows on consecutive cycles
    send(1, 24'hABCDE1, acc);
    send(2, 24'h123452, acc);
    send(3, 24'hFFFFFF, acc);
    idle(LAT + 2);
    check(q[1].size() + q[2].size() + q[3].size() == 0, "R4",
          q[1].size() + q[2].size() + q[3].size(), 0);

    // same row back to back: order kept, paced by the gap
    chk_exact = 0;
    for (int i = 0; i < 3; i++) send(0, AW'(24'h0A0000 + i), acc);
    idle(LAT + 3 * GAP + 2);
    check(q[0].size() == 0, "R5", q[0].size(), 0);

    // fill row 3 until it refuses; refused addresses must never appear
    refused = 0;
    for (int i = 0; i < 12; i++) begin
      send(3, AW'(24'h300000 + i), acc);
      if (!acc) refused++;
    end
    check(refused > 0, "R7", refused, 1);
    send(0, 24'h0BEEF0, acc);
    check(acc, "R8", int'(acc), 1);
    idle(40);
    check(q[3].size() == 0 && q[0].size() == 0, "R7", q[3].size(), 0);

    // constrained random traffic
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(99) < 70) send(int'($urandom_range(ROWS-1)), AW'($urandom), acc);
      else idle(0);
    end
    idle(60);
    for (int r = 0; r < ROWS; r++)
      check(q[r].size() == 0, "R9", q[r].size(), 0);
    finish_run();
  end
endmodule